// File: doc/BRIEF.md
# Peripheral DMA Channel

This block is one single-direction DMA channel that sits beside a serial peripheral. It moves data between the peripheral's data register and system memory with no processor involvement. Software programs a 32-bit memory pointer and a 16-bit beat counter through the peripheral's own register port. Each peripheral request that arrives while the counter is nonzero then produces exactly one memory beat. After the beat, the pointer steps forward and the counter counts down.

When the counter reaches zero, the channel raises a completion flag that can drive an interrupt, and it stays idle until software loads a new count. The direction is fixed for each instance by a parameter. A receive channel writes peripheral data into memory. A transmit channel reads memory and hands the word to the peripheral.

The peripheral side is a request/acknowledge stream. The peripheral holds `per_req` (the valid) and, for a receive channel, `per_rx_data` steady until it sees `per_ack`, which is high for exactly one cycle per beat. The memory side uses back-pressure in the same way: `mem_req` and `mem_addr` stay put until `mem_gnt` is sampled high, and the beat completes in that grant cycle. Read data must be valid in the grant cycle. One idle cycle separates consecutive beats.

Top module: `periph_dma_chan`

## Requirements
- R1: After reset the pointer reads 0, the counter reads 0, `xfer_done` is 1, and `mem_req` and `per_ack` are 0.
- R2: The register port uses `reg_addr` 0 for the pointer (32 bits), 1 for the counter (written from bits 15:0, read back zero-extended) and 2 for status (bit 0 is the completion flag). Address 3 reads 0. Reads are combinational and return live values while a transfer is under way.
- R3: A beat is launched only when the counter is nonzero and `per_req` is high at a clock edge. `mem_req` rises in the following cycle. With a zero counter, `mem_req` and `per_ack` stay 0 whatever `per_req` does.
- R4: Once raised, `mem_req` stays high and `mem_addr` holds the pointer value captured at launch until `mem_gnt` is high.
- R5: `per_ack` is high exactly in the cycle where `mem_req` and `mem_gnt` are both high, which gives one acknowledge per beat.
- R6: At the end of each beat, the pointer advances by the transfer size (1 byte by default, wrapping at 2^32) and the counter decreases by 1.
- R7: `xfer_done` is 1 exactly when the counter is 0. A beat that takes the counter from 1 to 0 sets it, writing a nonzero count clears it and re-arms the channel, and writing 0 sets it.
- R8: With `IS_RX`=1, `mem_we` is 1 and `mem_wdata` equals `per_rx_data`. With `IS_RX`=0, `mem_we` is 0 and `per_tx_data` equals `mem_rdata` during the grant cycle.
- R9: A software write to the pointer or to the counter in the same cycle as a beat completion takes priority for that register. The other register still updates from the beat.
- R10: If the counter is 0 when an in-flight beat completes, the counter stays 0 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| per_req | input | 1 | Peripheral beat request (valid) |
| per_ack | output | 1 | Beat acknowledge to the peripheral |
| per_rx_data | input | DATA_W | Received word to store (receive channel) |
| per_tx_data | output | DATA_W | Word fetched for the peripheral (transmit channel) |
| mem_req | output | 1 | Memory beat request |
| mem_gnt | input | 1 | Memory grant; the beat completes in this cycle |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with the grant |
| xfer_done | output | 1 | Completion flag and interrupt source |

## Verification
Two functions can land in the same cycle: a software write to the counter, and the counter update from a completing beat. The bench provokes this by asserting the counter write strobe in the very cycle it raises the memory grant. It then reads the registers back and expects the written count, with no decrement, while the pointer has still advanced. In a second case, zero is written while a beat waits for its grant. That beat must still complete without the counter wrapping below zero.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic {
    BEAT_IDLE = 1'b0,
    BEAT_WAIT = 1'b1
  } beat_state_e;

  localparam int REG_W = 32;
endpackage

// File: rtl/dmac_ptr_reg.sv
module dmac_ptr_reg #(
  parameter int ADDR_W     = 32,
  parameter int XFER_BYTES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr_q
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(XFER_BYTES);

  // a software write beats the beat-driven advance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (wr_en) ptr_q <= wdata;
    else if (adv)   ptr_q <= ptr_q + STEP;
  end
endmodule

// File: rtl/dmac_cnt_reg.sv
module dmac_cnt_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wdata,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic             zero
);
  assign zero = (cnt_q == '0);

  // write wins; a beat landing on zero leaves it at zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (wr_en)         cnt_q <= wdata;
    else if (dec && !zero)  cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/dmac_beat_fsm.sv
module dmac_beat_fsm
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_req,
  input  logic              armed,
  input  logic [ADDR_W-1:0] ptr_q,
  input  logic              mem_gnt,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              beat_done
);
  beat_state_e state_q;
  logic [ADDR_W-1:0] addr_q;

  assign mem_req   = (state_q == BEAT_WAIT);
  assign mem_addr  = addr_q;
  assign beat_done = mem_req && mem_gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BEAT_IDLE;
      addr_q  <= '0;
    end else begin
      case (state_q)
        BEAT_IDLE: if (per_req && armed) begin
          state_q <= BEAT_WAIT;
          addr_q  <= ptr_q;
        end
        BEAT_WAIT: if (mem_gnt) state_q <= BEAT_IDLE;
        default:   state_q <= BEAT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/periph_dma_chan.sv
module periph_dma_chan
  import dmac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 8,
  parameter int XFER_BYTES = 1,
  parameter bit IS_RX      = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              per_req,
  output logic              per_ack,
  input  logic [DATA_W-1:0] per_rx_data,
  output logic [DATA_W-1:0] per_tx_data,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              xfer_done
);
  reg_sel_e          sel;
  logic              wr_ptr, wr_cnt, beat_done, cnt_zero;
  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  assign sel    = reg_sel_e'(reg_addr);
  assign wr_ptr = reg_wr_en && (sel == SEL_PTR);
  assign wr_cnt = reg_wr_en && (sel == SEL_CNT);

  dmac_ptr_reg #(.ADDR_W(ADDR_W), .XFER_BYTES(XFER_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ptr),
    .wdata(ADDR_W'(reg_wdata)), .adv(beat_done), .ptr_q(ptr_q)
  );

  dmac_cnt_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cnt),
    .wdata(reg_wdata[CNT_W-1:0]), .dec(beat_done),
    .cnt_q(cnt_q), .zero(cnt_zero)
  );

  dmac_beat_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .per_req(per_req), .armed(!cnt_zero),
    .ptr_q(ptr_q), .mem_gnt(mem_gnt), .mem_req(mem_req),
    .mem_addr(mem_addr), .beat_done(beat_done)
  );

  assign per_ack   = beat_done;
  assign xfer_done = cnt_zero;

  // direction chosen per instance
  assign mem_we      = IS_RX;
  assign mem_wdata   = IS_RX ? per_rx_data : '0;
  assign per_tx_data = IS_RX ? '0 : mem_rdata;

  always_comb begin
    case (sel)
      SEL_PTR:  reg_rdata = REG_W'(ptr_q);
      SEL_CNT:  reg_rdata = REG_W'(cnt_q);
      SEL_STAT: reg_rdata = REG_W'(cnt_zero);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [1:0]        reg_addr,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              per_ack,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              xfer_done
);
  logic cnt_wr;
  assign cnt_wr = reg_wr_en && (reg_addr == 2'd1);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  // R5
  ack_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> mem_req && mem_gnt);

  // R3
  start_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(cnt_q) != '0);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack && !cnt_wr && cnt_q != '0 |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R7
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack && !cnt_wr && cnt_q == CNT_W'(1) |=> xfer_done);

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == '0 && !cnt_wr |=> cnt_q == '0);
endmodule

bind periph_dma_chan dmac_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
  .per_ack(per_ack), .cnt_q(cnt_q), .xfer_done(xfer_done)
);

// File: tb/periph_dma_chan_tb.sv
module periph_dma_chan_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic per_req = 1'b0, per_ack;
  logic [7:0] per_rx_data = '0, per_tx_data;
  logic mem_req, mem_gnt = 1'b0, mem_we;
  logic [31:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = '0;
  logic xfer_done;

  logic t_wr_en = 1'b0, t_per_req = 1'b0, t_gnt = 1'b0;
  logic [1:0] t_addr = 2'd0;
  logic [31:0] t_wdata = '0, t_rdata, t_maddr;
  logic t_ack, t_mreq, t_we, t_done;
  logic [7:0] t_txd, t_mwd, t_mrd = '0;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  periph_dma_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
    .per_ack(per_ack), .per_rx_data(per_rx_data), .per_tx_data(per_tx_data),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .xfer_done(xfer_done)
  );

  periph_dma_chan #(.IS_RX(1'b0)) u_dut_tx (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(t_wr_en), .reg_addr(t_addr),
    .reg_wdata(t_wdata), .reg_rdata(t_rdata), .per_req(t_per_req),
    .per_ack(t_ack), .per_rx_data(8'h00), .per_tx_data(t_txd),
    .mem_req(t_mreq), .mem_gnt(t_gnt), .mem_addr(t_maddr), .mem_we(t_we),
    .mem_wdata(t_mwd), .mem_rdata(t_mrd), .xfer_done(t_done)
  );

  // {pointer, count, grant delay, pad}
  localparam logic [63:0] VEC [4] = '{
    {32'h0000_1000, 16'd3, 8'd0, 8'd0},
    {32'h2000_0FFE, 16'd2, 8'd2, 8'd0},
    {32'hFFFF_FFFF, 16'd2, 8'd1, 8'd0},
    {32'h0000_0040, 16'd1, 8'd3, 8'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  // one beat; wr_cnt_at: 0 none, 1 counter write with grant, 2 counter write while waiting
  task automatic beat(input int dly, input logic [7:0] d, input logic [31:0] exp_addr,
                      input int wr_cnt_at, input logic [31:0] cval);
    @(negedge clk);
    per_req = 1'b1; per_rx_data = d;
    @(negedge clk);
    chk(mem_req == 1'b1, "R3 mem_req after request", 32'(mem_req), 1);
    for (int i = 0; i < dly; i++) begin
      if (wr_cnt_at == 2 && i == 0) begin
        reg_wr_en = 1'b1; reg_addr = 2'd1; reg_wdata = cval;
      end
      @(negedge clk);
      reg_wr_en = 1'b0;
      chk(mem_req && !per_ack && mem_addr == exp_addr, "R4 hold while waiting", mem_addr, exp_addr);
    end
    mem_gnt = 1'b1;
    if (wr_cnt_at == 1) begin
      reg_wr_en = 1'b1; reg_addr = 2'd1; reg_wdata = cval;
    end
    #1;
    chk(per_ack == 1'b1, "R5 ack with grant", 32'(per_ack), 1);
    chk(mem_addr == exp_addr, "R4 beat address", mem_addr, exp_addr);
    chk(mem_we && mem_wdata == d, "R8 receive write data", {23'd0, mem_we, mem_wdata}, {23'd0, 1'b1, d});
    @(negedge clk);
    mem_gnt = 1'b0; per_req = 1'b0; reg_wr_en = 1'b0;
    #1 chk(per_ack == 1'b0 && mem_req == 1'b0, "R5 single ack", 32'(per_ack), 0);
  endtask

  initial begin
    logic [31:0] v, p, a;
    int c, dly;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(2'd0, v); chk(v == 0, "R1 pointer reset", v, 0);
    rd_reg(2'd1, v); chk(v == 0, "R1 counter reset", v, 0);
    chk(xfer_done && !mem_req && !per_ack, "R1 flags reset", {xfer_done, mem_req, per_ack}, 32'b100);
    rd_reg(2'd3, v); chk(v == 0, "R2 unused address", v, 0);

    // R3 no start with zero count
    per_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!mem_req && !per_ack, "R3 idle at zero count", {mem_req, per_ack}, 0);
    end
    per_req = 1'b0;

    // table walk
    for (int e = 0; e < 4; e++) begin
      p = VEC[e][63:32]; c = int'(VEC[e][31:16]); dly = int'(VEC[e][15:8]);
      wr_reg(2'd0, p);
      wr_reg(2'd1, {16'hABCD, 16'(c)});
      rd_reg(2'd1, v); chk(v == 32'(c), "R2 counter zero-extended", v, 32'(c));
      rd_reg(2'd2, v); chk(v == 0, "R7 nonzero write clears done", v, 0);
      a = p;
      for (int b = 0; b < c; b++) begin
        beat(dly, p[7:0] ^ 8'(b), a, 0, 0);
        a = a + 1;
        rd_reg(2'd0, v); chk(v == a, "R6 pointer step live", v, a);
        rd_reg(2'd1, v); chk(v == 32'(c - b - 1), "R6 counter step live", v, 32'(c - b - 1));
      end
      rd_reg(2'd2, v); chk(v == 1 && xfer_done, "R7 done at zero", v, 1);
    end

    // R9 counter write coincides with grant
    wr_reg(2'd0, 32'h0000_0500);
    wr_reg(2'd1, 32'd5);
    beat(1, 8'h3C, 32'h0000_0500, 1, 32'd9);
    rd_reg(2'd1, v); chk(v == 9, "R9 write wins counter", v, 9);
    rd_reg(2'd0, v); chk(v == 32'h501, "R9 pointer still advances", v, 32'h501);

    // R10 zero written while a beat waits
    beat(2, 8'h5A, 32'h0000_0501, 2, 32'd0);
    rd_reg(2'd1, v); chk(v == 0, "R10 no wrap", v, 0);
    rd_reg(2'd0, v); chk(v == 32'h502, "R10 pointer advances", v, 32'h502);
    rd_reg(2'd2, v); chk(v == 1, "R7 zero write sets done", v, 1);

    // R8 transmit instance
    @(negedge clk); t_wr_en = 1'b1; t_addr = 2'd0; t_wdata = 32'h0000_0800;
    @(negedge clk); t_addr = 2'd1; t_wdata = 32'd1;
    @(negedge clk); t_wr_en = 1'b0; t_per_req = 1'b1;
    @(negedge clk);
    chk(t_mreq && !t_we && t_maddr == 32'h800, "R8 transmit read request", t_maddr, 32'h800);
    t_gnt = 1'b1; t_mrd = 8'hA5;
    #1 chk(t_ack && t_txd == 8'hA5, "R8 transmit data", {23'd0, t_ack, t_txd}, {23'd0, 1'b1, 8'hA5});
    @(negedge clk); t_gnt = 1'b0; t_per_req = 1'b0;
    #1 chk(t_done == 1'b1, "R7 transmit done", 32'(t_done), 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule